// File: doc/BRIEF.md
# Carrier Burst and FSK Timer Modulator

This block turns a free-running compare timer into a square-wave carrier and modulates it. An up-counter advances on a count enable taken from either an internal or an external tick input. When the count reaches the active compare value, the counter restarts and a toggle flip-flop inverts. A compare value of N therefore gives a carrier half-period of N+1 counted ticks.

A 2-bit mode register picks what happens to the carrier. The carrier can be switched off. It can be gated by the toggle output of a companion timer. It can be gated by the data bit of a serial shifter. In the FSK mode, the data bit chooses which of two compare values sets the half-period.

The raw toggle state and a one-cycle match pulse are exported, so that a companion timer can be clocked from the carrier timer. The serial shifter and the companion timer sit outside the block and arrive as plain inputs.

Top module: `carrier_mod`

## Requirements
- R1: While `rst_ni` is low, and until a mode is written after it rises, `cnt_o`, `tog_o`, `match_o` and `carrier_o` stay 0. Reset leaves the mode register at 00 (disabled).
- R2: With `clk_sel_i`=0 only `int_tick_i` advances the counter; with `clk_sel_i`=1 only `ext_tick_i` does. A tick on the unselected input leaves `cnt_o` and `tog_o` unchanged.
- R3: On a counted tick with `cnt_o` ≥ the active compare value, `cnt_o` returns to 0, `tog_o` inverts, and `match_o` is 1 for the following clock cycle only. Otherwise `cnt_o` increments. A compare value of N gives the sequence 0..N, 0, and a compare value of 0 toggles on every tick.
- R4: Mode 00 (disabled) holds `cnt_o` at 0, `tog_o` at 0 and `carrier_o` low, whatever the tick inputs do.
- R5: In mode 01, `carrier_o` equals `tog_o` AND `gate_tmr_i`. The counter keeps running while the gate is low.
- R6: In mode 10, `carrier_o` equals `tog_o` AND `ser_data_i`.
- R7: In mode 11, `carrier_o` equals `tog_o`. The half-period uses `cmp1_i` when the latched data bit is 0 and `cmp2_i` when it is 1. The bit is latched from `ser_data_i` only at mode entry and at each restart, so a mid-period change of the data bit has no effect until the next restart.
- R8: A mode write (`mode_we_i`=1) with a value different from the current mode clears `cnt_o` and `tog_o` on that edge. This takes priority over any tick in the same cycle. Rewriting the current mode changes nothing.
- R9: Modes 01 and 10 always use `cmp1_i`; `cmp2_i` has no effect there.
- R10: If the compare value is lowered below the current count, the next counted tick restarts the counter. There is no run-out to counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 1 | Count source select: 0 internal, 1 external |
| int_tick_i | input | 1 | Internal count enable |
| ext_tick_i | input | 1 | External count enable |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_i | input | 2 | Mode value: 00 off, 01 timer-gated burst, 10 data-gated burst, 11 FSK |
| cmp1_i | input | CNT_W | Compare value 1 |
| cmp2_i | input | CNT_W | Compare value 2 (FSK only) |
| gate_tmr_i | input | 1 | Companion timer toggle output, gate for mode 01 |
| ser_data_i | input | 1 | Serial data bit, gate for mode 10, frequency select for mode 11 |
| carrier_o | output | 1 | Modulated carrier |
| tog_o | output | 1 | Toggle flip-flop state |
| match_o | output | 1 | One-cycle pulse after each restart |
| cnt_o | output | CNT_W | Current counter value |

## Verification
The bench builds the block with `CNT_W`=4. With this width a compare value of 9 can be followed by a lowered value of 3 while the count sits above it, which exercises the no-overflow restart. The two FSK periods of 5 and 3 ticks also stay short, so many restarts fit in a short run. Stimulus includes sparse and external ticks, gate and data toggling in the middle of a half-period, and mode rewrites in the same cycle as a tick.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
  typedef enum logic [1:0] {
    MODE_OFF       = 2'b00,
    MODE_BURST_TMR = 2'b01,
    MODE_BURST_SER = 2'b10,
    MODE_FSK       = 2'b11
  } mode_e;
endpackage

// File: rtl/carrier_tick_sel.sv
module carrier_tick_sel (
  input  logic clk_sel_i,
  input  logic int_tick_i,
  input  logic ext_tick_i,
  input  logic run_i,
  output logic tick_o
);
  assign tick_o = run_i & (clk_sel_i ? ext_tick_i : int_tick_i);
endmodule

// File: rtl/carrier_cnt.sv
module carrier_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tff_o,
  output logic             wrap_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             tff_q;
  logic             match_q;
  logic             hit;

  // >= so a lowered compare restarts at once instead of running to overflow
  assign hit    = (cnt_q >= cmp_i);
  assign wrap_o = tick_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      tff_q   <= 1'b0;
      match_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      tff_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= wrap_o;
      if (tick_i) begin
        if (hit) begin
          cnt_q <= '0;
          tff_q <= ~tff_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign tff_o   = tff_q;
  assign match_o = match_q;
endmodule

// File: rtl/carrier_gate.sv
module carrier_gate
  import carrier_pkg::*;
(
  input  mode_e mode_i,
  input  logic  tff_i,
  input  logic  gate_tmr_i,
  input  logic  ser_data_i,
  output logic  carrier_o
);
  always_comb begin
    unique case (mode_i)
      MODE_BURST_TMR: carrier_o = tff_i & gate_tmr_i;
      MODE_BURST_SER: carrier_o = tff_i & ser_data_i;
      MODE_FSK:       carrier_o = tff_i;
      default:        carrier_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/carrier_mod.sv
module carrier_mod
  import carrier_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_sel_i,
  input  logic             int_tick_i,
  input  logic             ext_tick_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic [CNT_W-1:0] cmp2_i,
  input  logic             gate_tmr_i,
  input  logic             ser_data_i,
  output logic             carrier_o,
  output logic             tog_o,
  output logic             match_o,
  output logic [CNT_W-1:0] cnt_o
);
  mode_e            mode_q;
  logic             sel_q;
  logic             mode_chg;
  logic             run;
  logic             tick_w;
  logic             wrap_w;
  logic [CNT_W-1:0] cmp_act;

  assign mode_chg = mode_we_i && (mode_e'(mode_i) != mode_q);
  assign run      = (mode_q != MODE_OFF);
  assign cmp_act  = sel_q ? cmp2_i : cmp1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      sel_q  <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= mode_e'(mode_i);
      sel_q  <= (mode_e'(mode_i) == MODE_FSK) & ser_data_i;
    end else if (wrap_w && mode_q == MODE_FSK) begin
      // frequency select only moves on a restart boundary
      sel_q <= ser_data_i;
    end
  end

  carrier_tick_sel u_tick (
    .clk_sel_i (clk_sel_i),
    .int_tick_i(int_tick_i),
    .ext_tick_i(ext_tick_i),
    .run_i     (run),
    .tick_o    (tick_w)
  );

  carrier_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (mode_chg || !run),
    .tick_i (tick_w),
    .cmp_i  (cmp_act),
    .cnt_o  (cnt_o),
    .tff_o  (tog_o),
    .wrap_o (wrap_w),
    .match_o(match_o)
  );

  carrier_gate u_gate (
    .mode_i    (mode_q),
    .tff_i     (tog_o),
    .gate_tmr_i(gate_tmr_i),
    .ser_data_i(ser_data_i),
    .carrier_o (carrier_o)
  );
endmodule

// File: rtl/carrier_mod_chk.sv
module carrier_mod_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_we_i,
  input logic [1:0]       mode_i,
  input logic             gate_tmr_i,
  input logic             ser_data_i,
  input logic             carrier_o,
  input logic             tog_o,
  input logic             match_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic [1:0]       mode_q,
  input logic             sel_q,
  input logic             tick_w,
  input logic             wrap_w
);
  logic chg;
  assign chg = mode_we_i && (mode_i != mode_q);

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_w && !chg) |=> ($stable(cnt_o) && $stable(tog_o))); // R2
  AST_WRAP_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_w && !chg) |=> (tog_o != $past(tog_o) && cnt_o == '0)); // R3
  AST_MATCH_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(wrap_w)); // R3
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00) |-> (!carrier_o && !tog_o && cnt_o == '0)); // R4
  AST_TMR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b01 && !gate_tmr_i) |-> !carrier_o); // R5
  AST_SER_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b10 && !ser_data_i) |-> !carrier_o); // R6
  AST_SEL_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> ($past(wrap_w) || $past(mode_we_i))); // R7
  AST_MODE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (cnt_o == '0 && !tog_o)); // R8
endmodule

bind carrier_mod carrier_mod_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_we_i (mode_we_i),
  .mode_i    (mode_i),
  .gate_tmr_i(gate_tmr_i),
  .ser_data_i(ser_data_i),
  .carrier_o (carrier_o),
  .tog_o     (tog_o),
  .match_o   (match_o),
  .cnt_o     (cnt_o),
  .mode_q    (mode_q),
  .sel_q     (sel_q),
  .tick_w    (tick_w),
  .wrap_w    (wrap_w)
);

// File: tb/carrier_mod_bench.sv
module carrier_mod_bench;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clk_sel_i = 1'b0, int_tick_i = 1'b0, ext_tick_i = 1'b0;
  logic         mode_we_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [W-1:0] cmp1_i = '0, cmp2_i = '0;
  logic         gate_tmr_i = 1'b0, ser_data_i = 1'b0;
  logic         carrier_o, tog_o, match_o;
  logic [W-1:0] cnt_o;

  carrier_mod #(.CNT_W(W)) u_carrier_mod (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    logic [W-1:0] cnt;
    logic         tog;
    logic         car;
    logic         mat;
    string        tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  logic         done = 1'b0;
  logic [1:0]   m_mode = 2'b00;
  logic [W-1:0] m_cnt = '0;
  logic         m_tff = 1'b0, m_sel = 1'b0, m_mat = 1'b0;

  task automatic model_reset();
    m_mode = 2'b00; m_cnt = '0; m_tff = 1'b0; m_sel = 1'b0; m_mat = 1'b0;
  endtask

  // drive at a negedge, predict the next posedge, wait to the next negedge
  task automatic step(input logic ti, input logic te, input string tag);
    logic t;
    logic [W-1:0] cv;
    exp_t e;
    int_tick_i = ti;
    ext_tick_i = te;
    if (mode_we_i && mode_i != m_mode) begin
      m_mode = mode_i; m_cnt = '0; m_tff = 1'b0; m_mat = 1'b0;
      m_sel = (mode_i == 2'b11) && ser_data_i;
    end else if (m_mode == 2'b00) begin
      m_cnt = '0; m_tff = 1'b0; m_mat = 1'b0;
    end else begin
      t = clk_sel_i ? te : ti;
      cv = m_sel ? cmp2_i : cmp1_i;
      m_mat = t && (m_cnt >= cv);
      if (t) begin
        if (m_cnt >= cv) begin
          m_cnt = '0; m_tff = ~m_tff;
          if (m_mode == 2'b11) m_sel = ser_data_i;
        end else m_cnt = m_cnt + 1'b1;
      end
    end
    e.cnt = m_cnt; e.tog = m_tff; e.mat = m_mat; e.tag = tag;
    case (m_mode)
      2'b01:   e.car = m_tff & gate_tmr_i;
      2'b10:   e.car = m_tff & ser_data_i;
      2'b11:   e.car = m_tff;
      default: e.car = 1'b0;
    endcase
    q.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic wr_mode(input logic [1:0] m, input logic ti, input string tag);
    mode_we_i = 1'b1; mode_i = m;
    step(ti, 1'b0, tag);
    mode_we_i = 1'b0;
  endtask

  task automatic run(input int n, input int every, input string tag);
    for (int i = 0; i < n; i++) step((i % every) == 0, 1'b0, tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (cnt_o !== e.cnt || tog_o !== e.tog || carrier_o !== e.car || match_o !== e.mat) begin
          failures++;
          $display("FAIL %s: act cnt=%0d tog=%b car=%b mat=%b exp cnt=%0d tog=%b car=%b mat=%b",
                   e.tag, cnt_o, tog_o, carrier_o, match_o, e.cnt, e.tog, e.car, e.mat);
        end
      end
    end
  end

  task automatic chk_reset(input string tag);
    checks++;
    if (cnt_o !== '0 || tog_o !== 1'b0 || carrier_o !== 1'b0 || match_o !== 1'b0) begin
      failures++;
      $display("FAIL %s: act cnt=%0d tog=%b car=%b mat=%b exp all 0",
               tag, cnt_o, tog_o, carrier_o, match_o);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int_tick_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_reset("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    model_reset();
    run(4, 1, "R1 mode cleared after reset");

    // timer-gated burst, compare 4
    cmp1_i = 4'd4; cmp2_i = 4'd1; gate_tmr_i = 1'b1;
    wr_mode(2'b01, 1'b1, "R8 enter mode 01");
    run(12, 1, "R3 R9 count 0..4");
    gate_tmr_i = 1'b0;
    run(6, 1, "R5 gate low");
    gate_tmr_i = 1'b1;
    run(6, 2, "R5 R3 sparse ticks");

    // source select
    clk_sel_i = 1'b1;
    run(4, 1, "R2 internal ignored");
    for (int i = 0; i < 8; i++) step(1'b0, i[0], "R2 external ticks");
    clk_sel_i = 1'b0;

    cmp1_i = 4'd0;
    run(5, 1, "R3 compare 0");
    cmp1_i = 4'd2;
    run(2, 1, "R3 compare 2");
    wr_mode(2'b01, 1'b1, "R8 same mode rewrite");
    run(3, 1, "R8 after rewrite");

    // data-gated burst
    cmp1_i = 4'd3; cmp2_i = 4'd0;
    wr_mode(2'b10, 1'b1, "R8 enter mode 10");
    for (int i = 0; i < 16; i++) begin
      ser_data_i = (i % 5) < 3;
      step(1'b1, 1'b0, "R6 R9 data gate");
    end

    // FSK: 0 -> cmp1 (4), 1 -> cmp2 (2)
    cmp1_i = 4'd4; cmp2_i = 4'd2; ser_data_i = 1'b0;
    wr_mode(2'b11, 1'b1, "R8 enter FSK");
    for (int i = 0; i < 30; i++) begin
      ser_data_i = ((i / 7) % 2) == 1;
      step(1'b1, 1'b0, "R7 FSK select");
    end
    ser_data_i = 1'b1;
    wr_mode(2'b01, 1'b1, "R8 leave FSK");
    ser_data_i = 1'b0;
    wr_mode(2'b11, 1'b1, "R8 R7 enter FSK data 0");
    run(6, 1, "R7 FSK cmp1");

    // lowered compare
    cmp1_i = 4'd9;
    wr_mode(2'b01, 1'b1, "R8 enter mode 01");
    run(8, 1, "R10 count up");
    cmp1_i = 4'd3;
    run(6, 1, "R10 lowered compare");

    wr_mode(2'b00, 1'b1, "R4 disable");
    run(5, 1, "R4 disabled");

    // asynchronous reset in the middle of a run
    wr_mode(2'b11, 1'b1, "R8 enter FSK");
    run(3, 1, "R7 pre-reset");
    repeat (2) @(posedge clk_i);
    #2;
    rst_ni = 1'b0;
    #1;
    chk_reset("R1 mid-run reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    run(3, 1, "R1 mode off after reset");

    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule